// File: doc/BRIEF.md
# Dual-mode watchdog timer

This block is a programmable watchdog. Software loads a timeout period, in units of an external 100 Hz tick, into a set of byte-wide period registers over a small parallel register bus. Every write to a period byte restarts the countdown. When the countdown runs out, a sticky timeout flag is set. This happens whatever mode is selected, as long as the period is nonzero.

Two control bits decide what else a timeout does. One bit arms the watchdog and the other selects the action.

- **Repeating interrupt.** Armed with the selector clear, a timeout raises an interrupt flag and drives the active-low interrupt output. A read of the status register clears it.
- **One-shot reset.** Armed with the selector set, a timeout produces an active-low reset pulse of a fixed number of ticks. When the pulse ends, the arm bit clears itself.

An all-zero period keeps the watchdog silent.

Register map (bus_addr):

| Address | Register | Contents |
|---|---|---|
| 0 | status | bit 0 timeout flag, bit 1 interrupt flag |
| 1 | mode | bit 0 arm, bit 1 selector |
| 2 | period byte 0 | low byte |
| 3 | period byte 1 | high byte |

Top module: `wdog_dual`

## Requirements
- R1: After reset, irq_n and rst_n are 1, and reads of address 0 (status) and address 1 (mode) return 0.
- R2: A write to any period byte (address 2 = low byte, 3 = high byte) reloads the countdown. A timeout then occurs on exactly the P-th tick after the last such write, P being the period value. No interrupt or reset action is seen before it.
- R3: A timeout with a nonzero period sets the timeout flag (status bit 0) in every mode.
- R4: With arm=1 (mode bit 0) and selector=0 (mode bit 1), a timeout sets the interrupt flag (status bit 1), and irq_n goes low after the tick edge.
- R5: A read of status returns the flags as they were before the read. It clears the interrupt flag, and irq_n is 1 from the next clock edge.
- R6: With arm=1 and selector=1, a timeout drives rst_n low from the tick edge. rst_n stays low for RST_TICKS further ticks, rises on the last of them, and the arm bit reads 0 from then on. irq_n stays 1.
- R7: With arm=0, a timeout sets only the timeout flag. irq_n and rst_n stay 1.
- R8: With all period bytes zero, no timeout occurs, whatever ticks arrive.
- R9: The timeout flag is sticky. Writing status with bit 0 = 0 clears it, and writing bit 0 = 1 leaves it unchanged.
- R10: The mode bits and the period bytes read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick | input | 1 | One-cycle 100 Hz time base strobe |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq_n | output | 1 | Active-low interrupt |
| rst_n | output | 1 | Active-low watchdog reset pulse |

## Verification
A countdown that is off by one shows up at irq_n or rst_n one tick early or late. Stimulus that samples the outputs after every tick therefore exposes it within a single period. A wrong mode decode shows up on the very timeout tick: the wrong output moves, or the right one stays quiet. A stuck or wrongly cleared flag appears in the next status read. A pulse counter that never finishes shows up as an arm bit that still reads 1 after RST_TICKS ticks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int ADR_STATUS = 0;
   localparam int ADR_MODE   = 1;
   localparam int ADR_PER0   = 2;
   localparam int BIT_TOF    = 0;
   localparam int BIT_IRF    = 1;
   localparam int BIT_ARM    = 0;
   localparam int BIT_SEL    = 1;

   typedef enum logic [1:0] {
      ACT_NONE  = 2'b00,
      ACT_IRQ   = 2'b01,
      ACT_PULSE = 2'b10
   } wd_action_e;

   function automatic wd_action_e decode_action(input logic arm, input logic sel);
      if (!arm)     return ACT_NONE;
      else if (sel) return ACT_PULSE;
      else          return ACT_IRQ;
   endfunction
endpackage

// File: rtl/wdog_count.sv
module wdog_count #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic [PER_W-1:0] period,
   input  logic             reload,
   input  logic [PER_W-1:0] reload_val,
   output logic             timeout
);
   logic [PER_W-1:0] cnt;
   logic             per_zero;

   assign per_zero = (period == '0);
   assign timeout  = tick && !reload && !per_zero && (cnt == PER_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt <= '0;
      end else if (reload) begin
         cnt <= reload_val;
      end else if (tick) begin
         if (per_zero)                                 cnt <= '0;
         else if ((cnt == PER_W'(1)) || (cnt == '0))   cnt <= period;
         else                                          cnt <= cnt - PER_W'(1);
      end
   end

   p_reload_r2: assert property (@(posedge clk) disable iff (rst)
      reload |=> (cnt == $past(reload_val)));
   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
      (!per_zero && !reload) |=> (cnt <= $past(period)));
   p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
      (per_zero && !reload) |=> !timeout);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
   parameter int RST_TICKS = 10,
   localparam int PCNT_W = $clog2(RST_TICKS + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic fire,
   output logic rst_n,
   output logic done
);
   logic [PCNT_W-1:0] pcnt;
   logic              active;

   assign active = (pcnt != '0);
   assign done   = tick && (pcnt == PCNT_W'(1));
   assign rst_n  = !active;

   always_ff @(posedge clk) begin
      if (rst)                  pcnt <= '0;
      else if (fire && !active) pcnt <= PCNT_W'(RST_TICKS);
      else if (tick && active)  pcnt <= pcnt - PCNT_W'(1);
   end

   p_start_r6: assert property (@(posedge clk) disable iff (rst)
      (fire && !active) |=> !rst_n);
   p_end_r6: assert property (@(posedge clk) disable iff (rst)
      done |=> rst_n);
   p_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (active && !tick) |=> (!rst_n && $stable(pcnt)));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int PER_BYTES = 2,
   parameter int ADDR_W = 2,
   localparam int PER_W = 8 * PER_BYTES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              timeout,
   input  logic              pulse_done,
   output logic              arm,
   output logic              sel,
   output logic [PER_W-1:0]  period,
   output logic              reload,
   output logic [PER_W-1:0]  reload_val,
   output logic              irq_n
);
   logic wr_status, rd_status, wr_mode;
   logic tof_q, irf_q, arm_q, sel_q;
   logic [PER_BYTES-1:0] wr_per;
   logic [7:0] per_q [PER_BYTES];
   wd_action_e act;

   assign wr_status = bus_en && bus_we  && (bus_addr == ADDR_W'(ADR_STATUS));
   assign rd_status = bus_en && !bus_we && (bus_addr == ADDR_W'(ADR_STATUS));
   assign wr_mode   = bus_en && bus_we  && (bus_addr == ADDR_W'(ADR_MODE));
   assign act       = decode_action(arm_q, sel_q);

   for (genvar i = 0; i < PER_BYTES; i++) begin : g_per
      assign wr_per[i] = bus_en && bus_we && (bus_addr == ADDR_W'(ADR_PER0 + i));
      always_ff @(posedge clk) begin
         if (wr_per[i]) per_q[i] <= bus_wdata;
      end
      assign period[8*i +: 8]     = per_q[i];
      assign reload_val[8*i +: 8] = wr_per[i] ? bus_wdata : per_q[i];
   end
   assign reload = |wr_per;

   always_ff @(posedge clk) begin
      if (rst) begin
         tof_q <= 1'b0;
         irf_q <= 1'b0;
         arm_q <= 1'b0;
         sel_q <= 1'b0;
      end else begin
         if (timeout)                            tof_q <= 1'b1;
         else if (wr_status && !bus_wdata[BIT_TOF]) tof_q <= 1'b0;
         if (timeout && (act == ACT_IRQ))        irf_q <= 1'b1;
         else if (rd_status)                     irf_q <= 1'b0;
         if (pulse_done)                         arm_q <= 1'b0;
         else if (wr_mode)                       arm_q <= bus_wdata[BIT_ARM];
         if (wr_mode)                            sel_q <= bus_wdata[BIT_SEL];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(ADR_STATUS)) begin
         bus_rdata[BIT_TOF] = tof_q;
         bus_rdata[BIT_IRF] = irf_q;
      end else if (bus_addr == ADDR_W'(ADR_MODE)) begin
         bus_rdata[BIT_ARM] = arm_q;
         bus_rdata[BIT_SEL] = sel_q;
      end
      for (int i = 0; i < PER_BYTES; i++) begin
         if (bus_addr == ADDR_W'(ADR_PER0 + i)) bus_rdata = per_q[i];
      end
   end

   assign arm   = arm_q;
   assign sel   = sel_q;
   assign irq_n = !irf_q;

   p_tof_set_r3: assert property (@(posedge clk) disable iff (rst)
      timeout |=> tof_q);
   p_tof_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      (tof_q && !(wr_status && !bus_wdata[BIT_TOF])) |=> tof_q);
   p_irq_rep_r4: assert property (@(posedge clk) disable iff (rst)
      (timeout && arm_q && !sel_q) |=> !irq_n);
   p_irq_off_r7: assert property (@(posedge clk) disable iff (rst)
      (timeout && !arm_q) |=> !$rose(irf_q));
   p_rd_clr_r5: assert property (@(posedge clk) disable iff (rst)
      (rd_status && !timeout) |=> irq_n);
   p_disarm_r6: assert property (@(posedge clk) disable iff (rst)
      pulse_done |=> !arm_q);
endmodule

// File: rtl/wdog_dual.sv
module wdog_dual #(
   parameter int PER_BYTES = 2,
   parameter int RST_TICKS = 10,
   localparam int ADDR_W = $clog2(PER_BYTES + 2),
   localparam int PER_W  = 8 * PER_BYTES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              irq_n,
   output logic              rst_n
);
   if (PER_BYTES < 1 || PER_BYTES > 4) begin : g_bad_bytes
      $error("wdog_dual: PER_BYTES must lie in 1..4");
   end
   if (RST_TICKS < 1) begin : g_bad_pulse
      $error("wdog_dual: RST_TICKS must be at least 1");
   end

   logic             arm, sel, timeout, pulse_done, reload;
   logic [PER_W-1:0] period, reload_val;

   wdog_regs #(.PER_BYTES(PER_BYTES), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .timeout(timeout), .pulse_done(pulse_done), .arm(arm), .sel(sel),
      .period(period), .reload(reload), .reload_val(reload_val), .irq_n(irq_n)
   );

   wdog_count #(.PER_W(PER_W)) u_count (
      .clk(clk), .rst(rst), .tick(tick), .period(period),
      .reload(reload), .reload_val(reload_val), .timeout(timeout)
   );

   wdog_pulse #(.RST_TICKS(RST_TICKS)) u_pulse (
      .clk(clk), .rst(rst), .tick(tick), .fire(timeout && arm && sel),
      .rst_n(rst_n), .done(pulse_done)
   );

   p_no_irq_in_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      (!rst_n && sel) |-> !$fell(irq_n));
endmodule

// File: tb/sim_wdog_dual.sv
module sim_wdog_dual;
   localparam int RT = 10;
   logic clk = 1'b0, rst = 1'b1, tick = 1'b0, bus_en = 1'b0, bus_we = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic irq_n, rst_n;
   int total = 0, bad = 0, cyc = 0;
   logic [7:0] d;

   wdog_dual #(.PER_BYTES(2), .RST_TICKS(RT)) u0 (
      .clk(clk), .rst(rst), .tick(tick), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_n(irq_n), .rst_n(rst_n)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   function automatic logic exp_irq_n(input int mode);
      return !((mode & 1) == 1 && (mode & 2) == 0);
   endfunction
   function automatic logic exp_rst_n(input int mode);
      return !(mode == 3);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total = total + 1;
      if (act != exp) begin
         bad = bad + 1;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int v);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(v);
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] v);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = 2'(a);
      #2 v = bus_rdata;
      @(negedge clk);
      bus_en = 1'b0;
   endtask

   task automatic tk();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      repeat ($urandom_range(0, 2)) @(negedge clk);
   endtask

   initial begin
      int seed;
      seed = $urandom(32'h1d5e);
      repeat (4) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      chk("R1 irq_n", irq_n, 1);
      chk("R1 rst_n", rst_n, 1);
      rd(0, d); chk("R1 status", d, 0);
      rd(1, d); chk("R1 mode", d, 0);
      // R10 readback
      wr(2, 8'hA5); wr(3, 8'h3C); wr(1, 3);
      rd(2, d); chk("R10 per0", d, 8'hA5);
      rd(3, d); chk("R10 per1", d, 8'h3C);
      rd(1, d); chk("R10 mode", d, 3);
      wr(1, 0);

      // random rounds: R2 R3 R4 R5 R6 R7
      for (int k = 0; k < 24; k++) begin
         int mode, p;
         mode = $urandom_range(0, 3);
         p = $urandom_range(1, 6);
         wr(1, mode); wr(2, p); wr(3, 0); wr(0, 0); rd(0, d);
         for (int t = 1; t < p; t++) begin
            tk();
            chk("R2 early irq_n", irq_n, 1);
            chk("R2 early rst_n", rst_n, 1);
         end
         tk();
         chk("R4/R7 irq_n at timeout", irq_n, exp_irq_n(mode));
         chk("R6/R7 rst_n at timeout", rst_n, exp_rst_n(mode));
         rd(0, d);
         chk("R3 timeout flag", d[0], 1);
         chk("R4/R5 irq flag read", d[1], !exp_irq_n(mode));
         chk("R5 irq_n after read", irq_n, 1);
         if (mode == 3) begin
            for (int t = 1; t <= RT; t++) begin
               tk();
               chk("R6 pulse width", rst_n, (t == RT) ? 1 : 0);
               chk("R6 irq_n in pulse", irq_n, 1);
            end
            rd(1, d);
            chk("R6 arm cleared", d[0], 0);
         end
      end

      // R2 restart on rewrite
      wr(1, 1); wr(2, 5); wr(3, 0); wr(0, 0); rd(0, d);
      tk(); tk(); tk();
      wr(3, 0);
      for (int t = 1; t < 5; t++) begin
         tk(); chk("R2 restart quiet", irq_n, 1);
      end
      tk(); chk("R2 restart fires", irq_n, 0);
      rd(0, d);

      // R8 zero period
      wr(2, 0); wr(3, 0); wr(0, 0); rd(0, d);
      for (int t = 0; t < 20; t++) tk();
      chk("R8 irq_n", irq_n, 1);
      rd(0, d); chk("R8 status", d, 0);

      // R9 sticky flag
      wr(1, 0); wr(2, 2); wr(3, 0);
      tk(); tk();
      wr(2, 0);
      wr(0, 8'hFF); rd(0, d); chk("R9 write 1 keeps", d[0], 1);
      wr(0, 8'hFE); rd(0, d); chk("R9 write 0 clears", d[0], 0);
      chk("R7 rst_n idle", rst_n, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule